// File: doc/BRIEF.md
# Preloaded Timer/Event Counter with Prescaler

This block is an 8-bit up-counter for a small controller core. It has two ways of counting. In timer mode it counts ticks from a power-of-two prescaler. The prescaler is fed either by the system clock or by a slow real-time tick. In event mode it counts rising edges of an external pin, after those edges have passed through a two-flop synchroniser. When the counter wraps past its all-ones value, it takes its next value from a separate preload register and raises an interrupt request flag.

Software uses two addresses on a simple register port: a control register and the counter/preload location. A preload write goes straight into the counter when the timer is stopped. While the timer runs, the write only updates the preload register, and the counter takes the new value at its next wrap. The interrupt output is the request flag gated by an enable bit.

Top module: `pretick_timer`

## Requirements
- R1: After reset, the control register reads 0x00 (address 0), the counter reads 0x00 (address 1), and `irqReq` is low.
- R2: Timer mode counts the system clock.
  - Setup: run (bit 5) = 1, source (bit 3) = 0, mode (bit 4) = 0, ratio code k in bits 2:0.
  - Rate: the counter advances once every 2^(k+1) clocks, so code 0 gives /2 and code 7 gives /256.
  - Start: the prescaler starts from zero on the write that sets run. The first increment lands on the 2^(k+1)-th rising edge after that write edge.
- R3: With source (bit 3) = 1, the prescaler counts single-cycle `rtcTick` pulses instead of clocks. The counter advances once every 2^(k+1) pulses and holds between pulses.
- R4: With mode (bit 4) = 1 and run set, each rising edge of `evtIn` advances the counter by one, on the third rising clock edge after `evtIn` goes high. A level held high counts only once, and the prescaler is bypassed.
- R5: With run (bit 5) = 0, the counter does not change in either mode.
- R6: On an increment from 0xFF, the counter loads the preload value on the same edge that sets the request flag, which reads back as control bit 7.
- R7: A write to address 1 while run = 0 updates both the preload register and the counter.
- R8: A write to address 1 while run = 1 leaves the counter unchanged. The new preload value is the one loaded at the next wrap.
- R9: `irqReq` is high only when the request flag and the enable (bit 6) are both set. Clearing the enable forces it low while the flag stays set.
- R10: A control write with bit 7 = 0 clears the request flag, and a control write with bit 7 = 1 leaves it unchanged. A wrap on the same edge sets the flag regardless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = control register, 1 = counter/preload |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| rtcTick | input | 1 | One-cycle pulse from the slow real-time source, already retimed to `clk` |
| evtIn | input | 1 | External event input, asynchronous |
| irqReq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Each result has a fixed latency after its stimulus:
- Register writes take effect on the write edge, and read data is combinational.
- In timer mode, the n-th increment after start falls on edge n·2^(k+1) counted from the write edge.
- A real-time pulse is counted on the edge where it is sampled.
- An event edge appears in the counter on the third clock edge after `evtIn` rises.

The bench drives inputs and samples outputs at the falling edge and counts rising edges explicitly from the write edge. Where an off-by-one in the design is plausible, it checks both the edge just before the expected change and the edge of the change.

// File: rtl/pretick_pkg.sv
package pretick_pkg;
  localparam int CNT_W       = 8;
  localparam int PS_STAGES   = 8;
  localparam int SEL_W       = $clog2(PS_STAGES);
  localparam int SYNC_STAGES = 2;
  localparam int BIT_SRC     = SEL_W;
  localparam int BIT_MODE    = SEL_W + 1;
  localparam int BIT_RUN     = SEL_W + 2;
  localparam int BIT_IEN     = SEL_W + 3;
  localparam int CTL_W       = SEL_W + 4;
  localparam logic ADDR_CTL  = 1'b0;
  localparam logic ADDR_CNT  = 1'b1;

  typedef struct packed {
    logic             cntTick;
    logic             preWr;
    logic             running;
    logic [CNT_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/pretick_ctrl.sv
module pretick_ctrl
  import pretick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [CNT_W-1:0] regWdata,
  input  logic             rtcTick,
  input  logic             evtIn,
  input  logic             ovf,
  output strobe_t          strb,
  output logic [CNT_W-1:0] ctrlView,
  output logic             irqReq
);
  logic [CTL_W-1:0]     ctrlQ;
  logic                 flagQ;
  logic [PS_STAGES-1:0] prescQ;
  logic [PS_STAGES-1:0] prescMask;
  logic [SYNC_STAGES:0] syncQ;
  logic                 ctrlWr, run, modeEvt, srcTick, prescHit, evtRise, cntTick;

  assign ctrlWr  = regWr && (regAddr == ADDR_CTL);
  assign run     = ctrlQ[BIT_RUN];
  assign modeEvt = ctrlQ[BIT_MODE];
  assign srcTick = ctrlQ[BIT_SRC] ? rtcTick : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= regWdata[CTL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else if (ovf) flagQ <= 1'b1;
    else if (ctrlWr && !regWdata[CTL_W]) flagQ <= 1'b0;
  end

  always_comb begin
    for (int i = 0; i < PS_STAGES; i++)
      prescMask[i] = (i <= int'(ctrlQ[SEL_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run || modeEvt) prescQ <= '0;
    else if (srcTick) prescQ <= prescQ + 1'b1;
  end

  assign prescHit = srcTick && ((prescQ & prescMask) == prescMask);

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[SYNC_STAGES-1:0], evtIn};
  end

  assign evtRise = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];
  assign cntTick = run && (modeEvt ? evtRise : prescHit);

  assign strb.cntTick = cntTick;
  assign strb.preWr   = regWr && (regAddr == ADDR_CNT);
  assign strb.running = run;
  assign strb.wdata   = regWdata;

  assign ctrlView = {flagQ, ctrlQ};
  assign irqReq   = flagQ && ctrlQ[BIT_IEN];

  // R2, R4: increments never occur on two consecutive edges
  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rstN)
    cntTick && !ctrlWr |=> !cntTick);
  // R6: a wrap sets the request flag
  p_flag_on_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> flagQ);
  // R10: clearing write without a coincident wrap clears the flag
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !regWdata[CTL_W] && !ovf |=> !flagQ);
endmodule

// File: rtl/pretick_dpath.sv
module pretick_dpath
  import pretick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] cntOut,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntQ, preQ;

  assign ovf = strb.cntTick && (cntQ == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) preQ <= '0;
    else if (strb.preWr) preQ <= strb.wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (strb.preWr && !strb.running) cntQ <= strb.wdata;
    else if (ovf) cntQ <= preQ;
    else if (strb.cntTick) cntQ <= cntQ + 1'b1;
  end

  assign cntOut = cntQ;

  // R6: wrap reloads the preload value held before the edge
  p_reload_on_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> cntQ == $past(preQ));
  // R7: stopped write lands in the counter
  p_stopped_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.preWr && !strb.running |=> cntQ == $past(strb.wdata));
  // R8: running write without a tick leaves the counter alone
  p_run_write_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.preWr && strb.running && !strb.cntTick |=> $stable(cntQ));
  // R5: no tick and no write means no change
  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntTick && !strb.preWr |=> $stable(cntQ));
endmodule

// File: rtl/pretick_timer.sv
module pretick_timer
  import pretick_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  input  logic             rtcTick,
  input  logic             evtIn,
  output logic             irqReq
);
  strobe_t          strb;
  logic [CNT_W-1:0] ctrlView, cntOut;
  logic             ovf;

  pretick_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .rtcTick(rtcTick), .evtIn(evtIn), .ovf(ovf), .strb(strb),
    .ctrlView(ctrlView), .irqReq(irqReq)
  );

  pretick_dpath uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cntOut(cntOut), .ovf(ovf)
  );

  assign regRdata = (regAddr == ADDR_CNT) ? cntOut : ctrlView;
endmodule

// File: tb/sim_pretick_timer.sv
`timescale 1ns/1ps
module sim_pretick_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       rtcTick = 1'b0;
  logic       evtIn = 1'b0;
  logic       irqReq;
  int         nChk = 0;
  int         nBad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pretick_timer u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rtcTick(rtcTick), .evtIn(evtIn), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkCnt(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(1'b1, v); chk(req, v, exp);
  endtask

  task automatic chkCtl(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rd(1'b0, v); chk(req, v, exp);
  endtask

  task automatic testReset();
    chkCtl("R1 ctrl", 8'h00);
    chkCnt("R1 count", 8'h00);
    chk("R1 irq", {7'd0, irqReq}, 8'h00);
  endtask

  task automatic testSysClock();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h20);                      // run, /2
    edges(1); chkCnt("R2 /2 before first", 8'h00);
    edges(1); chkCnt("R2 /2 first", 8'h01);
    edges(4); chkCnt("R2 /2 third", 8'h03);
    wr(1'b0, 8'h00);
    edges(5); chkCnt("R5 stopped holds", 8'h03);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h22);                      // run, /8
    edges(7); chkCnt("R2 /8 before first", 8'h00);
    edges(1); chkCnt("R2 /8 first", 8'h01);
    edges(16); chkCnt("R2 /8 third", 8'h03);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h27);                      // run, /256
    edges(255); chkCnt("R2 /256 before first", 8'h00);
    edges(1); chkCnt("R2 /256 first", 8'h01);
    wr(1'b0, 8'h00);
  endtask

  task automatic pulseRtc();
    rtcTick = 1'b1; @(posedge clk); @(negedge clk);
    rtcTick = 1'b0; edges(2);
  endtask

  task automatic testRtc();
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h29);                      // run, rtc source, /4
    edges(10); chkCnt("R3 no pulses", 8'h00);
    repeat (3) pulseRtc();
    chkCnt("R3 three pulses", 8'h00);
    pulseRtc();
    chkCnt("R3 four pulses", 8'h01);
    edges(9); chkCnt("R3 holds between pulses", 8'h01);
    wr(1'b0, 8'h00);
  endtask

  task automatic testEvent();
    wr(1'b1, 8'h10);
    chkCnt("R7 stopped preload", 8'h10);
    wr(1'b0, 8'h30);                      // run, event mode
    evtIn = 1'b1;
    edges(2); chkCnt("R4 before sync", 8'h10);
    edges(1); chkCnt("R4 first edge", 8'h11);
    edges(6); chkCnt("R4 level counts once", 8'h11);
    evtIn = 1'b0; edges(4);
    evtIn = 1'b1; edges(3); chkCnt("R4 second edge", 8'h12);
    evtIn = 1'b0;
    wr(1'b0, 8'h10);                      // stopped, event mode
    edges(3);
    evtIn = 1'b1; edges(5); chkCnt("R5 event while stopped", 8'h12);
    evtIn = 1'b0; edges(3);
    wr(1'b0, 8'h00);
  endtask

  task automatic testWrap();
    wr(1'b1, 8'h5A); chkCnt("R7 stopped write", 8'h5A);
    wr(1'b1, 8'hFE);
    wr(1'b0, 8'h20);                      // run, /2, enable off
    wr(1'b1, 8'h40); chkCnt("R8 running write held", 8'hFE);
    edges(1); chkCnt("R8 still counting", 8'hFF);
    chkCtl("R6 flag not yet", 8'h20);
    edges(2); chkCnt("R6 R8 reload new preload", 8'h40);
    chkCtl("R6 flag set", 8'hA0);
    chk("R9 irq masked", {7'd0, irqReq}, 8'h00);
    wr(1'b0, 8'hC0);                      // stop, enable, keep flag
    chkCtl("R10 flag kept", 8'hC0);
    chk("R9 irq asserted", {7'd0, irqReq}, 8'h01);
    wr(1'b0, 8'h80);                      // enable off, keep flag
    chk("R9 enable cleared", {7'd0, irqReq}, 8'h00);
    chkCtl("R9 flag survives", 8'h80);
    wr(1'b0, 8'h40);                      // enable on, clear flag
    chkCtl("R10 flag cleared", 8'h40);
    chk("R10 irq after clear", {7'd0, irqReq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSysClock();
    testRtc();
    testEvent();
    testWrap();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule